// File: doc/BRIEF.md
# Multichannel PWM timer

This block is a timer that generates several edge-aligned PWM outputs from one shared up-counter. A prescaler slows the counter to one step every 2^PS clocks. The counter runs from zero up to a 16-bit modulo value and then wraps, so every channel has the same period. Each channel compares the shared count with its own compare value and drives one output pin. A 2-bit output code selects normal or inverted polarity, or keeps the pin inactive.

Software controls the block through a word-addressed register port. Reads are combinational and writes take effect on the clock edge. While the counter is stopped, new period and compare values apply as soon as they are written. While it runs, they are held in shadow registers and move into the active registers only at the next period start. This prevents a torn period. Reads return the active value, so software can poll to see when a buffered write has landed. A per-channel event flag records compare hits and is cleared by writing 1 to it.

Top module: `pwm_timer`

## Requirements
- R1: After reset: the counter reads 0, the modulo register reads 0xFFFF, the status/control register and every channel control and compare register read 0, and all PWM outputs are low.
- R2: Address 0x04 reads the number of channels in bits [7:0]. Address 0x08 always reads 0, and writes to it are ignored.
- R3: The status/control register at 0x10 has these fields: bits [2:0] prescale code, bits [4:3] clock mode, bit 5 centre-align select. Bit 5 is stored and read back but does not change counting. Bits above 5 read 0.
- R4: With clock mode 01, the counter at 0x14 advances once every 2^PS clocks. In any other mode it holds its value. Writes to 0x14 are ignored.
- R5: On each step the counter goes from its current value to value+1. When the current value is greater than or equal to the active modulo, it goes to 0 instead. The period is therefore modulo+1 steps.
- R6: With clock mode 00, a write to the modulo register (0x18) or to a channel compare register (0x24+8n) becomes active at once. It reads back on the next cycle as the low 16 bits of the write data, zero-extended.
- R7: With a nonzero clock mode, such writes are held. Reads keep returning the old active value until the step on which the counter wraps to 0. A write made in that same cycle applies at that boundary.
- R8: Channel control at 0x20+8n stores bits [5:2]. Bit 5 enables edge-aligned PWM. Bits [3:2] are the output code: 10 and 11 give normal polarity, 01 gives inverted polarity, and 00 gives a low output. When bit 5 is clear the output is low. Bits 6, 1 and 0 read 0.
- R9: With normal polarity, a channel output is high while count < compare and low otherwise. Inverted polarity gives the complement. A change to channel control shows on the pin in the cycle after the write, without waiting for a period boundary.
- R10: Channel control bit 7 is set on a counting step where count equals the active compare value. Writing 1 to bit 7 clears it, and writing 0 leaves it unchanged. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
The bench builds the block with three channels, an 8-bit address and a 16-bit counter. Three channels is not the default of four, which shows that the channel-count field reports the parameter rather than a fixed value. The last channel then sits at 0x30/0x34, which exercises the stride decode at its top end. The 16-bit counter, narrower than the data word, lets an oversized compare write show its truncation. The same counter width lets a modulo reduced below the current count show the forced wrap.

// File: rtl/pwm_timer_pkg.sv
// Shared constants and types for the PWM timer.
// Assumes word-aligned register offsets below 0x100.
package pwm_timer_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned PS_W      = 3;
    localparam int unsigned CH_STRIDE = 8;

    localparam logic [7:0] OFS_INFO    = 8'h04;
    localparam logic [7:0] OFS_GLOBAL  = 8'h08;
    localparam logic [7:0] OFS_SC      = 8'h10;
    localparam logic [7:0] OFS_CNT     = 8'h14;
    localparam logic [7:0] OFS_MOD     = 8'h18;
    localparam logic [7:0] OFS_CH_BASE = 8'h20;

    typedef enum logic [1:0] {
        CLK_OFF = 2'b00,
        CLK_INT = 2'b01,
        CLK_EXT = 2'b10,
        CLK_RSV = 2'b11
    } clk_mode_e;

    typedef enum logic [1:0] {
        OUT_OFF  = 2'b00,
        OUT_INV  = 2'b01,
        OUT_NORM = 2'b10,
        OUT_RSV  = 2'b11
    } out_code_e;

    // Status/control word, bits [5:0].
    typedef struct packed {
        logic            center;
        clk_mode_e       mode;
        logic [PS_W-1:0] ps;
    } sc_t;

    // Channel configuration, bits [5:2] of the channel control word.
    typedef struct packed {
        logic      edge_en;
        logic      mode_b;
        out_code_e code;
    } ch_cfg_t;

endpackage

// File: rtl/pwm_timebase.sv
// Prescaler, shared up-counter and buffered modulo register.
// Assumes run implies defer (a counting timer always defers writes).
module pwm_timebase
    import pwm_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PS_W-1:0]  ps,
    input  logic             run,
    input  logic             defer,
    input  logic             mod_we,
    input  logic [CNT_W-1:0] mod_wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] mod_o,
    output logic             tick_o,
    output logic             wrap_o
);
    localparam int unsigned PRE_W = (1 << PS_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_mask;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mod_buf_q;
    logic [CNT_W-1:0] mod_q;

    assign pre_mask = ~({PRE_W{1'b1}} << ps);
    assign tick_o   = run && ((pre_q & pre_mask) == pre_mask);
    assign wrap_o   = tick_o && (cnt_q >= mod_q);
    assign cnt_o    = cnt_q;
    assign mod_o    = mod_q;

    // Free-running prescale divider, cleared while the counter is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end

    // Shared counter: steps on each tick and wraps at the active modulo.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
    end

    // Modulo shadow and active registers: immediate when stopped, else at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_buf_q <= '1;
            mod_q     <= '1;
        end else begin
            if (mod_we) mod_buf_q <= mod_wdata;
            if (!defer && mod_we)   mod_q <= mod_wdata;
            else if (defer && wrap_o) mod_q <= mod_we ? mod_wdata : mod_buf_q;
        end
    end

    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && cnt_q >= mod_q) |=> (cnt_q == '0));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q));

    assert_mod_defer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (defer && !wrap_o) |=> $stable(mod_q));

endmodule

// File: rtl/pwm_channel.sv
// One PWM channel: configuration, buffered compare value, event flag, pin.
// Assumes tick/wrap/cnt come from the shared timebase of the same clock.
module pwm_channel
    import pwm_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wrap,
    input  logic             defer,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    input  logic             val_we,
    input  logic [CNT_W-1:0] val_wdata,
    output logic [7:0]       cfg_rd,
    output logic [CNT_W-1:0] val_o,
    output logic             pwm_o
);
    ch_cfg_t          cfg_q;
    logic             flag_q;
    logic [CNT_W-1:0] val_buf_q;
    logic [CNT_W-1:0] val_q;
    logic             hit;
    logic             below;
    logic             unused_cfg;

    assign unused_cfg = ^{cfg_wdata[6], cfg_wdata[1:0]};
    assign hit    = tick && (cnt == val_q);
    assign below  = cnt < val_q;
    assign cfg_rd = {flag_q, 1'b0, cfg_q, 2'b00};
    assign val_o  = val_q;

    // Channel configuration: applies immediately on write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= ch_cfg_t'(cfg_wdata[5:2]);
    end

    // Event flag: set by a compare hit, cleared by writing 1; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag_q <= 1'b0;
        else if (hit)                   flag_q <= 1'b1;
        else if (cfg_we && cfg_wdata[7]) flag_q <= 1'b0;
    end

    // Compare shadow and active registers: immediate when stopped, else at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_buf_q <= '0;
            val_q     <= '0;
        end else begin
            if (val_we) val_buf_q <= val_wdata;
            if (!defer && val_we)   val_q <= val_wdata;
            else if (defer && wrap) val_q <= val_we ? val_wdata : val_buf_q;
        end
    end

    // Output decode from the configuration, count and active compare.
    always_comb begin
        unique case (cfg_q.code)
            OUT_OFF: pwm_o = 1'b0;
            OUT_INV: pwm_o = cfg_q.edge_en && !below;
            default: pwm_o = cfg_q.edge_en && below;
        endcase
    end

    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);

    assert_flag_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(cfg_we && cfg_wdata[7])) |=> flag_q);

    assert_val_defer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (defer && !wrap) |=> $stable(val_q));

endmodule

// File: rtl/pwm_timer.sv
// Multichannel edge-aligned PWM timer with a word-addressed register port.
// Assumes ADDR_W >= 8, CNT_W < 32 and NUM_CH <= 28 so every offset fits.
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pwm_o
);
    localparam logic [7:0] CH_COUNT = 8'(NUM_CH);

    sc_t              sc_q;
    logic             run;
    logic             defer;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mod_act;
    logic [7:0]       ch_cfg_rd [NUM_CH];
    logic [CNT_W-1:0] ch_val    [NUM_CH];
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:CNT_W];
    assign run   = (sc_q.mode == CLK_INT);
    assign defer = (sc_q.mode != CLK_OFF);

    function automatic logic [ADDR_W-1:0] cfg_addr(input int unsigned idx);
        return ADDR_W'(OFS_CH_BASE) + ADDR_W'(CH_STRIDE * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] val_addr(input int unsigned idx);
        return cfg_addr(idx) + ADDR_W'(4);
    endfunction

    // Status/control register write.
    always_ff @(posedge clk) begin
        if (!rst_n) sc_q <= '0;
        else if (reg_we && reg_addr == ADDR_W'(OFS_SC)) sc_q <= sc_t'(reg_wdata[5:0]);
    end

    pwm_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .ps        (sc_q.ps),
        .run       (run),
        .defer     (defer),
        .mod_we    (reg_we && reg_addr == ADDR_W'(OFS_MOD)),
        .mod_wdata (reg_wdata[CNT_W-1:0]),
        .cnt_o     (cnt),
        .mod_o     (mod_act),
        .tick_o    (tick),
        .wrap_o    (wrap)
    );

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .wrap      (wrap),
            .defer     (defer),
            .cnt       (cnt),
            .cfg_we    (reg_we && reg_addr == cfg_addr(gi)),
            .cfg_wdata (reg_wdata[7:0]),
            .val_we    (reg_we && reg_addr == val_addr(gi)),
            .val_wdata (reg_wdata[CNT_W-1:0]),
            .cfg_rd    (ch_cfg_rd[gi]),
            .val_o     (ch_val[gi]),
            .pwm_o     (pwm_o[gi])
        );
    end

    // Read mux; unmapped words, including the global register, read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_INFO))     reg_rdata = DATA_W'(CH_COUNT);
        else if (reg_addr == ADDR_W'(OFS_SC))  reg_rdata = DATA_W'(sc_q);
        else if (reg_addr == ADDR_W'(OFS_CNT)) reg_rdata = DATA_W'(cnt);
        else if (reg_addr == ADDR_W'(OFS_MOD)) reg_rdata = DATA_W'(mod_act);
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == cfg_addr(i)) reg_rdata = DATA_W'(ch_cfg_rd[i]);
            if (reg_addr == val_addr(i)) reg_rdata = DATA_W'(ch_val[i]);
        end
    end

    assert_sc_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == ADDR_W'(OFS_SC)) |=> $stable(sc_q));

endmodule

// File: tb/test_pwm_timer.sv
module test_pwm_timer;
    localparam int unsigned NUM_CH = 3;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic              reg_we = 1'b0;
    logic [31:0]       reg_rdata;
    logic [NUM_CH-1:0] pwm_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwm_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_pwm_timer (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pwm_o(pwm_o)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] expv;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{8'h04, 32'h0000_0000, 32'h0000_0003, 8'd2},  // R2 channel count
        '{8'h08, 32'hFFFF_FFFF, 32'h0000_0000, 8'd2},  // R2 global ignored
        '{8'h10, 32'hFFFF_FF20, 32'h0000_0020, 8'd3},  // R3 centre bit stored
        '{8'h10, 32'h0000_0000, 32'h0000_0000, 8'd3},  // R3
        '{8'h14, 32'h0000_0055, 32'h0000_0000, 8'd4},  // R4 count not writable
        '{8'h18, 32'h0000_0009, 32'h0000_0009, 8'd6},  // R6 modulo immediate
        '{8'h24, 32'h0000_0004, 32'h0000_0004, 8'd6},  // R6 ch0 compare
        '{8'h2C, 32'h0000_0005, 32'h0000_0005, 8'd6},  // R6 ch1 compare
        '{8'h34, 32'h0001_2345, 32'h0000_2345, 8'd6},  // R6 ch2 truncated
        '{8'h30, 32'h0000_00FF, 32'h0000_003C, 8'd8},  // R8 stored bits
        '{8'h30, 32'h0000_0000, 32'h0000_0000, 8'd8}   // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_cnt(input logic [31:0] v);
        logic [31:0] d;
        for (int n = 0; n < 64; n++) begin
            rd(8'h14, d);
            if (d == v) return;
            @(negedge clk);
        end
        check("R5 wait", d, v);
    endtask

    function automatic logic [31:0] step(input logic [31:0] c, input logic [31:0] m);
        return (c >= m) ? 32'd0 : c + 32'd1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, c0, c1, ce;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h10, d); check("R1 sc", d, 0);
        rd(8'h14, d); check("R1 cnt", d, 0);
        rd(8'h18, d); check("R1 mod", d, 32'hFFFF);
        rd(8'h20, d); check("R1 cfg", d, 0);
        rd(8'h24, d); check("R1 val", d, 0);
        check("R1 pwm", 32'(pwm_o), 0);

        // Register vector table, counter stopped
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i].addr, VECS[i].wdata);
            rd(VECS[i].addr, d);
            check($sformatf("R%0d table %0d", VECS[i].req, i), d, VECS[i].expv);
        end

        // R8 R9 output codes at count 0, compare 4
        wr(8'h20, 32'h28); #1; check("R9 normal high", 32'(pwm_o[0]), 1);
        wr(8'h20, 32'h24); #1; check("R9 inverted low", 32'(pwm_o[0]), 0);
        wr(8'h20, 32'h20); #1; check("R8 code 00 off", 32'(pwm_o[0]), 0);
        wr(8'h20, 32'h08); #1; check("R8 edge bit clear", 32'(pwm_o[0]), 0);
        wr(8'h20, 32'h2C); #1; check("R8 code 11 normal", 32'(pwm_o[0]), 1);
        wr(8'h20, 32'h28);

        // R4 R5 R9 run at prescale 0, modulo 9, compare 4
        wr(8'h10, 32'h08);
        reg_addr = 8'h14;
        for (int k = 0; k < 20; k++) begin
            #1;
            check("R5 count", reg_rdata, 32'(k % 10));
            check("R9 pwm run", 32'(pwm_o[0]), 32'((k % 10) < 4));
            @(negedge clk);
        end

        // R4 stop holds counter
        wr(8'h10, 32'h00);
        rd(8'h14, c1);
        repeat (5) @(negedge clk);
        rd(8'h14, d); check("R4 stopped hold", d, c1);

        // R10 flag set by hit, kept by write 0, cleared by write 1
        rd(8'h20, d); check("R10 flag set", d, 32'hA8);
        wr(8'h20, 32'h28); rd(8'h20, d); check("R10 write 0 keeps", d, 32'hA8);
        wr(8'h20, 32'hA8); rd(8'h20, d); check("R10 write 1 clears", d, 32'h28);

        // R7 buffered writes while running
        wr(8'h10, 32'h08);
        wait_cnt(2);
        wr(8'h18, 32'h5);
        wr(8'h24, 32'h7);
        rd(8'h18, d); check("R7 mod held", d, 9);
        rd(8'h24, d); check("R7 val held", d, 4);
        wait_cnt(0);
        rd(8'h18, d); check("R7 mod applied", d, 5);
        rd(8'h24, d); check("R7 val applied", d, 7);
        reg_addr = 8'h14;
        for (int k = 0; k < 12; k++) begin
            #1;
            check("R5 new period", reg_rdata, 32'(k % 6));
            check("R9 compare above mod", 32'(pwm_o[0]), 1);
            @(negedge clk);
        end

        // R4 prescale code 2: one step every 4 clocks
        wr(8'h10, 32'h00);
        rd(8'h14, c0);
        wr(8'h10, 32'h0A);
        reg_addr = 8'h14;
        for (int j = 0; j < 13; j++) begin
            ce = c0;
            for (int s = 0; s < j / 4; s++) ce = step(ce, 5);
            #1;
            check("R4 prescale", reg_rdata, ce);
            @(negedge clk);
        end

        // R4 R7 mode 10 holds counter but still defers writes
        wr(8'h10, 32'h10);
        rd(8'h14, c1);
        repeat (5) @(negedge clk);
        rd(8'h14, d); check("R4 mode 10 hold", d, c1);
        wr(8'h18, 32'h8);
        rd(8'h18, d); check("R7 mode 10 deferred", d, 5);

        // R5 count above a reduced modulo wraps on the next step
        wr(8'h10, 32'h00);
        wr(8'h18, 32'h9);
        wr(8'h10, 32'h08);
        wait_cnt(7);
        wr(8'h10, 32'h00);
        rd(8'h14, d); check("R5 parked at 9", d, 9);
        wr(8'h18, 32'h3);
        rd(8'h18, d); check("R6 stopped mod", d, 3);
        wr(8'h10, 32'h08);
        reg_addr = 8'h14;
        #1; check("R5 above mod", reg_rdata, 9);
        @(negedge clk); #1; check("R5 forced wrap", reg_rdata, 0);
        @(negedge clk); #1; check("R5 after wrap", reg_rdata, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule